// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. It finds out whether an embedded program or erase operation inside the flash has finished. After the command sequence has started the operation elsewhere, the host pulses `start`. The poller then issues status read cycles over a read-request/acknowledge handshake, always at one fixed status address. It compares a selected toggle bit across each pair of back-to-back reads.

When the toggle bit holds still, the operation is over and the poller reports `done`. If the bit moves and the timeout flag in the same returned byte is set, the poller tests one more pair of reads. This covers the case where toggling stopped just as the flag rose. If that pair still toggles, the poller writes the reset command to return the flash to array reading, waits for the write to be acknowledged, and reports `fail`. If the bit moves but the flag is clear, the poller keeps polling. When `pause` is high it stops with `abandoned` instead, and a later `start` begins again from a fresh pair of reads. An optional pair counter forces the failure path when polling never resolves.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy`, `rd_req`, `wr_req`, `done`, `fail` and `abandoned` are all low.
- R2: Every status read presents `rd_addr` equal to the parameter `STATUS_ADDR`. `rd_req` stays high until a cycle with `rd_ack` high. Reads and writes are never requested together.
- R3: If the toggle bit is equal in both reads of the first pair, `done` pulses for one cycle, `busy` falls with it, and no write is issued.
- R4: If the toggle bit differs and bit 5 of the second read of the pair is 0, with `pause` low, the poller starts another pair of reads. It reports `done` once a pair shows no toggle.
- R5: If the toggle bit differs and bit 5 of the second read is 1, exactly one more pair is read. If that pair does not toggle, `done` pulses.
- R6: If the extra pair of R5 still toggles, whatever bit 5 holds, one write of `RST_DATA` to `RST_ADDR` is issued. `fail` pulses in the cycle after the write's acknowledge cycle.
- R7: If the toggle bit differs, bit 5 is 0 and `pause` is high at the end of the pair, `abandoned` pulses and no write is issued. A following `start` begins a fresh first pair.
- R8: With `MAX_POLLS` nonzero, if the `MAX_POLLS`-th pair since `start` still toggles with bit 5 at 0, the poller takes the failure path of R6. With `MAX_POLLS` at 0 this limit is disabled.
- R9: The toggle bit is bit `TGL_BIT` of `rd_data` (6 by default, 2 as the alternative). Motion on the other candidate bit is ignored.
- R10: `start` has no effect while `busy` is high. At most one of `done`, `fail` and `abandoned` is high in any cycle, and `busy` falls only together with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling from a fresh pair of reads |
| pause | input | 1 | Stop at the next unresolved pair and report abandoned |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_addr | output | ADDR_W | Status address for the read |
| rd_ack | input | 1 | Read completes this cycle; rd_data valid |
| rd_data | input | 8 | Status byte returned by the flash |
| wr_req | output | 1 | Reset-command write request, held until acknowledged |
| wr_addr | output | ADDR_W | Reset-command address |
| wr_data | output | 8 | Reset-command data |
| wr_ack | input | 1 | Write completes this cycle |
| busy | output | 1 | Polling or reset write in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed, reset written |
| abandoned | output | 1 | One-cycle pulse: polling paused before resolution |

## Verification
The embedded assertions assume that `rd_ack` is high only while `rd_req` is high and that `wr_ack` is high only while `wr_req` is high, each for a single cycle per request. The bench's bus responder only raises an acknowledge after it has seen the matching request at a falling edge, and it drops the acknowledge at the next falling edge. It serves read data from a scripted queue of status bytes, so each scenario fixes exactly which toggle and flag values the poller sees. `start` and `pause` change only at falling edges, away from the edges where the poller samples them.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int FLAG_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_RST_WRITE
    } poll_state_e;

    typedef struct packed {
        logic done;
        logic fail;
        logic abandoned;
    } poll_result_t;

    function automatic logic pick_bit(input logic [7:0] data, input int idx);
        return data[idx];
    endfunction

endpackage

// File: rtl/tgl_compare.sv
module tgl_compare
    import flash_poll_pkg::*;
#(
    parameter int TGL_BIT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic [7:0] din,
    output logic       toggled,
    output logic       flag
);

    logic first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
        end else if (capture) begin
            first_q <= pick_bit(din, TGL_BIT);
        end
    end

    assign toggled = first_q ^ pick_bit(din, TGL_BIT);
    assign flag    = din[FLAG_BIT];

    initial begin
        a_r9_bit_choice : assert (TGL_BIT == 6 || TGL_BIT == 2);
    end

endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic last_pair
);

    localparam int CNT_W = $clog2(MAX_POLLS + 2);

    generate
        if (MAX_POLLS == 0) begin : g_off
            assign last_pair = 1'b0;
        end else begin : g_on
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt <= '0;
                end else if (tick && cnt < CNT_W'(MAX_POLLS)) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign last_pair = (cnt >= CNT_W'(MAX_POLLS - 1));

            a_r8_cnt_bound : assert property (@(posedge clk) disable iff (rst)
                cnt <= CNT_W'(MAX_POLLS));
        end
    endgenerate

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import flash_poll_pkg::*;
#(
    parameter int              ADDR_W      = 20,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] RST_ADDR    = '0,
    parameter logic [7:0]      RST_DATA    = 8'hF0,
    parameter int              TGL_BIT     = 6,
    parameter int              MAX_POLLS   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pause,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              abandoned
);

    poll_state_e  state;
    logic         recheck;
    poll_result_t res_q;
    logic         toggled;
    logic         flag;
    logic         last_pair;
    logic         pair_end;

    assign pair_end = (state == ST_RD_SECOND) && rd_ack;

    tgl_compare #(.TGL_BIT(TGL_BIT)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .capture ((state == ST_RD_FIRST) && rd_ack),
        .din     (rd_data),
        .toggled (toggled),
        .flag    (flag)
    );

    poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .clear     ((state == ST_IDLE) && start),
        .tick      (pair_end),
        .last_pair (last_pair)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            recheck <= 1'b0;
            res_q   <= '0;
        end else begin
            res_q <= '0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_RD_FIRST;
                        recheck <= 1'b0;
                    end
                end
                ST_RD_FIRST: begin
                    if (rd_ack) state <= ST_RD_SECOND;
                end
                ST_RD_SECOND: begin
                    if (rd_ack) begin
                        if (!toggled) begin
                            res_q.done <= 1'b1;
                            state      <= ST_IDLE;
                        end else if (recheck) begin
                            state <= ST_RST_WRITE;
                        end else if (flag) begin
                            recheck <= 1'b1;
                            state   <= ST_RD_FIRST;
                        end else if (last_pair) begin
                            state <= ST_RST_WRITE;
                        end else if (pause) begin
                            res_q.abandoned <= 1'b1;
                            state           <= ST_IDLE;
                        end else begin
                            state <= ST_RD_FIRST;
                        end
                    end
                end
                ST_RST_WRITE: begin
                    if (wr_ack) begin
                        res_q.fail <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req    = (state == ST_RD_FIRST) || (state == ST_RD_SECOND);
    assign rd_addr   = STATUS_ADDR;
    assign wr_req    = (state == ST_RST_WRITE);
    assign wr_addr   = RST_ADDR;
    assign wr_data   = RST_DATA;
    assign busy      = (state != ST_IDLE);
    assign done      = res_q.done;
    assign fail      = res_q.fail;
    assign abandoned = res_q.abandoned;

    a_r2_no_overlap : assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    a_r2_read_held : assert property (@(posedge clk) disable iff (rst)
        ($past(rd_req) && !$past(rd_ack)) |-> rd_req);

    a_r6_write_held : assert property (@(posedge clk) disable iff (rst)
        ($past(wr_req) && !$past(wr_ack)) |-> wr_req);

    a_r6_fail_after_write : assert property (@(posedge clk) disable iff (rst)
        fail |-> $past(wr_req && wr_ack));

    a_r3_done_after_read : assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(rd_req && rd_ack) && !busy && !wr_req));

    a_r7_abandon_after_read : assert property (@(posedge clk) disable iff (rst)
        abandoned |-> ($past(rd_req && rd_ack) && !busy));

    a_r10_one_result : assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fail, abandoned}));

    a_r10_busy_ends_with_result : assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || fail || abandoned));

endmodule

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;

    localparam int         ADDR_W = 20;
    localparam logic [19:0] ST_A  = 20'h00AAA;
    localparam logic [19:0] RS_A  = 20'h00555;
    localparam logic [7:0]  RS_D  = 8'hF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic pause = 1'b0;
    logic rd_req, rd_ack, wr_req, wr_ack;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic busy, done, fail, abandoned;

    always #4 clk = ~clk;

    flash_toggle_poller #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(ST_A), .RST_ADDR(RS_A),
        .RST_DATA(RS_D), .TGL_BIT(6), .MAX_POLLS(4)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .pause(pause),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .done(done), .fail(fail), .abandoned(abandoned)
    );

    typedef struct {
        int    kind;
        int    reads;
        int    writes;
        string tag;
    } exp_t;

    int checks = 0;
    int errors = 0;
    int n_reads = 0;
    int n_writes = 0;
    int cycles = 0;
    logic [7:0] rdq[$];
    exp_t expq[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // read responder: one-cycle acknowledge after a request is seen
    initial begin
        rd_ack = 1'b0;
        rd_data = 8'h00;
        forever begin
            @(negedge clk);
            if (rd_req && !rd_ack) begin
                chk(rd_addr == ST_A, "R2 status address", int'(rd_addr), int'(ST_A));
                rd_data = (rdq.size() != 0) ? rdq.pop_front() : 8'h00;
                rd_ack = 1'b1;
                n_reads++;
            end else begin
                rd_ack = 1'b0;
            end
        end
    end

    // write responder
    initial begin
        wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (wr_req && !wr_ack) begin
                chk(wr_addr == RS_A, "R6 reset address", int'(wr_addr), int'(RS_A));
                chk(wr_data == RS_D, "R6 reset data", int'(wr_data), int'(RS_D));
                wr_ack = 1'b1;
                n_writes++;
            end else begin
                wr_ack = 1'b0;
            end
        end
    end

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (!rst && (done || fail || abandoned)) begin
            int kind;
            kind = done ? 0 : (fail ? 1 : 2);
            if (expq.size() == 0) begin
                chk(1'b0, "R10 unexpected result", kind, -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(kind == e.kind, {e.tag, " result kind"}, kind, e.kind);
                chk(n_reads == e.reads, {e.tag, " read count"}, n_reads, e.reads);
                chk(n_writes == e.writes, {e.tag, " write count"}, n_writes, e.writes);
                chk(!busy, "R10 busy low with result", int'(busy), 0);
            end
        end
    end

    task automatic run(input logic [7:0] bytes[$], input int kind, input int reads,
                       input int writes, input string tag, input bit mid_start);
        exp_t e;
        e.kind = kind; e.reads = reads; e.writes = writes; e.tag = tag;
        expq.push_back(e);
        rdq = bytes;
        n_reads = 0;
        n_writes = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (mid_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req && !wr_req, {tag, " idle after result"}, int'(busy), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, rd_req, wr_req, done, fail, abandoned} == 6'b0, "R1 reset state",
            int'({busy, rd_req, wr_req, done, fail, abandoned}), 0);

        run('{8'h44, 8'h44}, 0, 2, 0, "R3 steady pair", 1'b0);
        run('{8'h04, 8'h00}, 0, 2, 0, "R9 other bit ignored", 1'b0);
        run('{8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00}, 0, 6, 0,
            "R4 keep polling with R10 start ignored", 1'b1);
        run('{8'h40, 8'h20, 8'h20, 8'h20}, 0, 4, 0, "R5 recheck settles", 1'b0);
        run('{8'h40, 8'h20, 8'h60, 8'h20}, 1, 4, 1, "R6 recheck toggles", 1'b0);
        run('{8'h40, 8'h20, 8'h40, 8'h00}, 1, 4, 1, "R6 recheck toggles flag low", 1'b0);
        pause = 1'b1;
        run('{8'h40, 8'h00}, 2, 2, 0, "R7 paused", 1'b0);
        pause = 1'b0;
        run('{8'h40, 8'h40}, 0, 2, 0, "R7 resume fresh pair", 1'b0);
        run('{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00}, 1, 8, 1,
            "R8 poll limit", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule